// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block starts conversions on an external successive-approximation converter that has an active-low start line and an active-low busy output. User logic hands over a start request through a valid/ready pair. The sequencer drives the start line low for a fixed short pulse and then returns it high. It watches the converter's busy line fall and later rise, and reports completion with a one-clock done pulse.

The converter is sensitive to edges on its digital inputs while it converts. The sequencer therefore keeps the start line static from the end of the pulse until busy has risen again, and then waits a short settle window. It keeps successive start edges at least one conversion-plus-acquisition period apart. It also guarantees a minimum high time on the start line before each new falling edge. A request that is not yet legal is held and issued on the first cycle that all limits allow. If the converter never lowers busy, or never raises it again, the sequencer sets a sticky error flag and goes back to idle.

All limits are given in nanoseconds and converted to clock cycles from the clock frequency, rounding up. The request interface holds one request. `start_ready` is low while a request is waiting, and user logic must keep `start_valid` high until it sees `start_ready`, so a request is never lost. The busy input is asynchronous and passes through a synchronizer before it is used.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset `conv_n_o` is high, `done_o` and `err_o` are low and `start_ready` is high.
- R2: A request is accepted on a clock edge where `start_valid` and `start_ready` are both high. `start_ready` is low from the edge after acceptance until the edge on which that request's start pulse begins. Every accepted request produces exactly one start pulse.
- R3: Each start pulse holds `conv_n_o` low for exactly ceil(PULSE_NS·f/1e9) cycles. `conv_n_o` then stays high and does not change until the conversion has ended.
- R4: Two falling edges of `conv_n_o` are at least PERIOD cycles apart. A held request issues on the first cycle allowed by R4, R5 and R10. A request accepted while idle with all windows open falls `conv_n_o` two edges after `start_valid` is driven.
- R5: `conv_n_o` is high for at least ceil(HIGH_NS·f/1e9) cycles before every falling edge.
- R6: If busy is still high BF cycles after the edge that lowered `conv_n_o`, `err_o` rises on exactly that edge and the sequencer returns to idle.
- R7: If busy has not been seen rising within RISE cycles of the edge that lowered `conv_n_o`, `err_o` rises on exactly that edge and the sequencer returns to idle.
- R8: `err_o` stays high until reset, and later conversions still run normally while it is high.
- R9: `done_o` is high for exactly one cycle, two clock edges after the first edge that samples busy high again. Only a conversion this block started produces it.
- R10: A new falling edge of `conv_n_o` comes at least SETTLE+2 cycles after the cycle in which `done_o` was high.
- R11: Busy activity while no conversion is running produces neither `done_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Conversion request valid |
| start_ready | output | 1 | Request slot free; handshake completes when both are high |
| busy_n_i | input | 1 | Converter busy, low while converting, asynchronous |
| conv_n_o | output | 1 | Active-low conversion start to the converter |
| done_o | output | 1 | One-cycle pulse when a started conversion finishes |
| err_o | output | 1 | Sticky flag for a busy timeout |

## Verification
The hardest case to reach is a held request whose legal issue cycle is set by a different limit from one conversion to the next. The restart period, the high time and the post-busy settle window can each be the binding one, and the request can arrive at any cycle inside the previous conversion. The bench sweeps the request offset across every cycle of the restart period. It does this under two busy-low durations, one short enough that the period binds and one long enough that the settle window binds, and predicts each falling edge as the maximum of the three limits. The timeout edges are reached by a converter model that can withhold either busy transition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PULSE,
    SQ_WAIT_LO,
    SQ_WAIT_HI,
    SQ_SETTLE
  } seq_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(longint ns, longint hz);
    longint prod;
    longint cyc;
    prod = ns * hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_busy_sync.sv
module adc_seq_busy_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= IDLE_LVL;
        else        chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{IDLE_LVL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IDLE_LVL;
    else        last_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int LIMIT = 16,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] SAT = W'(LIMIT);

  // saturating up-counter; restart loads one so the value read at an edge
  // equals the number of edges since the restart edge
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_o <= SAT;
    else if (restart_i)      cnt_o <= W'(1);
    else if (cnt_o != SAT)   cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/adc_seq_rate_gate.sv
module adc_seq_rate_gate #(
  parameter int PERIOD_CYC = 2500,
  parameter int HIGH_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic conv_n_i,
  output logic open_o
);

  localparam int GW = $clog2(PERIOD_CYC + 1);
  localparam int HW = $clog2(HIGH_CYC + 1);
  localparam logic [GW-1:0] GAP_L = GW'(PERIOD_CYC);
  localparam logic [HW-1:0] HI_L  = HW'(HIGH_CYC);

  logic [GW-1:0] gap_cnt;
  logic [HW-1:0] hi_cnt;

  // cycles since the last start edge
  adc_seq_tick #(.LIMIT(PERIOD_CYC), .W(GW)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (issue_i),
    .cnt_o     (gap_cnt)
  );

  // cycles the start line has been high
  adc_seq_tick #(.LIMIT(HIGH_CYC), .W(HW)) u_high (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (~conv_n_i),
    .cnt_o     (hi_cnt)
  );

  assign open_o = (gap_cnt >= GAP_L) && (hi_cnt >= HI_L);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter longint CLK_FREQ_HZ = 100_000_000,
  parameter int     PERIOD_NS   = 25_000,
  parameter int     PULSE_NS    = 100,
  parameter int     HIGH_NS     = 15,
  parameter int     BF_NS       = 400,
  parameter int     RISE_NS     = 25_000,
  parameter int     SETTLE_NS   = 50,
  parameter int     SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_valid,
  output logic start_ready,
  input  logic busy_n_i,
  output logic conv_n_o,
  output logic done_o,
  output logic err_o
);

  localparam int PERIOD_CYC = ns_to_cyc(PERIOD_NS, CLK_FREQ_HZ);
  localparam int PULSE_CYC  = ns_to_cyc(PULSE_NS,  CLK_FREQ_HZ);
  localparam int HIGH_CYC   = ns_to_cyc(HIGH_NS,   CLK_FREQ_HZ);
  localparam int BF_CYC     = ns_to_cyc(BF_NS,     CLK_FREQ_HZ);
  localparam int RISE_CYC   = ns_to_cyc(RISE_NS,   CLK_FREQ_HZ);
  localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_FREQ_HZ);
  localparam int TMO_LIMIT  = max2(max2(PULSE_CYC, BF_CYC), max2(RISE_CYC, SETTLE_CYC));
  localparam int TW         = $clog2(TMO_LIMIT + 1);

  localparam logic [TW-1:0] PULSE_L  = TW'(PULSE_CYC);
  localparam logic [TW-1:0] BF_L     = TW'(BF_CYC);
  localparam logic [TW-1:0] RISE_L   = TW'(RISE_CYC);
  localparam logic [TW-1:0] SETTLE_L = TW'(SETTLE_CYC);

  seq_state_e    st_q, st_d;
  logic          conv_q, conv_d;
  logic          err_q, err_d;
  logic          pend_q, pend_d;
  logic          issue;
  logic          tmr_restart;
  logic [TW-1:0] tmr;
  logic          gate_open;
  logic          bsy_lvl;
  logic          bsy_rise;

  // busy is asynchronous: synchronize, then detect the rising edge
  adc_seq_busy_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (busy_n_i),
    .lvl_o   (bsy_lvl),
    .rise_o  (bsy_rise)
  );

  // restart period and minimum high time
  adc_seq_rate_gate #(.PERIOD_CYC(PERIOD_CYC), .HIGH_CYC(HIGH_CYC)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue),
    .conv_n_i (conv_q),
    .open_o   (gate_open)
  );

  // one timer for pulse width, both busy timeouts and the settle window
  adc_seq_tick #(.LIMIT(TMO_LIMIT), .W(TW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .cnt_o     (tmr)
  );

  always_comb begin
    st_d        = st_q;
    conv_d      = conv_q;
    err_d       = err_q;
    pend_d      = pend_q;
    issue       = 1'b0;
    tmr_restart = 1'b0;
    if (start_valid && !pend_q) pend_d = 1'b1;
    unique case (st_q)
      SQ_IDLE: begin
        if (pend_q && gate_open) begin
          issue       = 1'b1;
          pend_d      = 1'b0;
          conv_d      = 1'b0;
          tmr_restart = 1'b1;
          st_d        = SQ_PULSE;
        end
      end
      SQ_PULSE: begin
        if (tmr >= PULSE_L) begin
          conv_d = 1'b1;
          st_d   = SQ_WAIT_LO;
        end
      end
      SQ_WAIT_LO: begin
        // level test: busy usually falls while the pulse is still low
        if (!bsy_lvl) begin
          st_d = SQ_WAIT_HI;
        end else if (tmr >= BF_L) begin
          err_d = 1'b1;
          st_d  = SQ_IDLE;
        end
      end
      SQ_WAIT_HI: begin
        if (bsy_rise) begin
          tmr_restart = 1'b1;
          st_d        = SQ_SETTLE;
        end else if (tmr >= RISE_L) begin
          err_d = 1'b1;
          st_d  = SQ_IDLE;
        end
      end
      SQ_SETTLE: begin
        if (tmr >= SETTLE_L) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      conv_q <= 1'b1;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      conv_q <= conv_d;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end

  assign start_ready = ~pend_q;
  assign conv_n_o    = conv_q;
  assign err_o       = err_q;
  assign done_o      = (st_q == SQ_WAIT_HI) && bsy_rise;

  // ---------------------------------------------------------------
  // Assertions with independent observation counters
  // ---------------------------------------------------------------
  localparam int CGW = $clog2(PERIOD_CYC + 1);
  localparam int CHW = $clog2(HIGH_CYC + 1);
  localparam logic [CGW-1:0] CG_SAT = CGW'(PERIOD_CYC);
  localparam logic [CHW-1:0] CH_SAT = CHW'(HIGH_CYC);

  logic           obs_conv_q;
  logic [CGW-1:0] obs_gap_q;
  logic [CHW-1:0] obs_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obs_conv_q <= 1'b1;
      obs_gap_q  <= CG_SAT;
      obs_hi_q   <= CH_SAT;
    end else begin
      obs_conv_q <= conv_n_o;
      if (!conv_n_o && obs_conv_q) obs_gap_q <= CGW'(1);
      else if (obs_gap_q != CG_SAT) obs_gap_q <= obs_gap_q + 1'b1;
      if (!conv_n_o) obs_hi_q <= '0;
      else if (obs_hi_q != CH_SAT) obs_hi_q <= obs_hi_q + 1'b1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready); // R2

  AST_QUIET_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT_HI && $past(st_q == SQ_WAIT_HI)) |-> $stable(conv_n_o)); // R3

  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n_o) |-> (obs_gap_q >= CG_SAT)); // R4

  AST_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n_o) |-> (obs_hi_q >= CH_SAT)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

endmodule

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;

  localparam int PERIOD_NS = 1000;
  localparam int PULSE_NS  = 100;
  localparam int HIGH_NS   = 15;
  localparam int BF_NS     = 400;
  localparam int RISE_NS   = 1500;
  localparam int SETTLE_NS = 50;
  // 100 MHz: 10 ns per cycle, rounded up
  localparam int P_CYC = (PERIOD_NS + 9) / 10;
  localparam int PW    = (PULSE_NS  + 9) / 10;
  localparam int HC    = (HIGH_NS   + 9) / 10;
  localparam int BF    = (BF_NS     + 9) / 10;
  localparam int RT    = (RISE_NS   + 9) / 10;
  localparam int SET   = (SETTLE_NS + 9) / 10;
  localparam int FD    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic busy_n = 1'b1;
  logic start_ready, conv_n, done, err;

  adc_conv_sequencer #(
    .CLK_FREQ_HZ (100_000_000),
    .PERIOD_NS   (PERIOD_NS),
    .PULSE_NS    (PULSE_NS),
    .HIGH_NS     (HIGH_NS),
    .BF_NS       (BF_NS),
    .RISE_NS     (RISE_NS),
    .SETTLE_NS   (SETTLE_NS),
    .SYNC_STAGES (2)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .busy_n_i    (busy_n),
    .conv_n_o    (conv_n),
    .done_o      (done),
    .err_o       (err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- converter model ----------------
  bit fall_en = 1;
  bit rise_en = 1;
  int bl = 20;

  initial begin
    forever begin
      @(negedge conv_n);
      repeat (FD) @(posedge clk);
      #1;
      if (fall_en) busy_n = 1'b0;
      repeat (bl) @(posedge clk);
      #1;
      if (rise_en) busy_n = 1'b1;
    end
  end

  // ---------------- port monitor ----------------
  int nfalls = 0, ndone = 0, nreq = 0;
  int last_fall = 0, last_done = 0, busy_rise = -100;
  int hi_run = 1000, lo_run = 0;
  bit conv_prev = 1, busy_prev = 1, done_prev = 0;
  bit gap_ref = 0, done_ref = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      conv_prev = 1; busy_prev = 1; done_prev = 0;
      hi_run = 1000; lo_run = 0; gap_ref = 0; done_ref = 0;
    end else begin
      if (busy_n && !busy_prev) busy_rise = cyc;
      if (conv_prev && !conv_n) begin
        chk(hi_run >= HC, "R5 high time", hi_run, HC);
        if (gap_ref) chk(cyc - last_fall >= P_CYC, "R4 restart gap", cyc - last_fall, P_CYC);
        if (done_ref) chk(cyc - last_done >= SET + 2, "R10 settle", cyc - last_done, SET + 2);
        nfalls++; last_fall = cyc; lo_run = 0; gap_ref = 1; done_ref = 0;
      end
      if (!conv_prev && conv_n) begin
        chk(lo_run == PW, "R3 pulse width", lo_run, PW);
        hi_run = 0;
      end
      if (conv_n) hi_run++; else lo_run++;
      if (done) begin
        chk(!done_prev, "R9 single cycle", done_prev, 0);
        chk(cyc == busy_rise + 2, "R9 done timing", cyc, busy_rise + 2);
        ndone++; last_done = cyc; done_ref = 1;
      end
      conv_prev = conv_n; busy_prev = busy_n; done_prev = done;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_req(output int m);
    @(posedge clk); #1;
    chk(start_ready == 1'b1, "R2 ready before request", start_ready, 1);
    start_valid = 1'b1; m = cyc; nreq++;
    @(posedge clk); #1;
    start_valid = 1'b0;
    chk(start_ready == 1'b0, "R2 ready low while held", start_ready, 0);
  endtask

  task automatic wait_falls(input int n);
    while (nfalls < n) @(posedge clk);
  endtask

  task automatic wait_dones(input int n);
    while (ndone < n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
  endtask

  int mA, mB, fA, expB, dn0, f0;

  initial begin
    repeat (4) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    chk(conv_n == 1'b1, "R1 conv idle high", conv_n, 1);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(err == 1'b0, "R1 err low", err, 0);
    chk(start_ready == 1'b1, "R1 ready high", start_ready, 1);

    // R11: busy glitch with no conversion running
    dn0 = ndone;
    @(posedge clk); #1; busy_n = 1'b0;
    repeat (5) @(posedge clk);
    #1; busy_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(ndone == dn0, "R11 no done from idle busy", ndone, dn0);
    chk(err == 1'b0, "R11 no err from idle busy", err, 0);
    chk(conv_n == 1'b1, "R11 conv untouched", conv_n, 1);

    // sweep of request offset against two busy-low durations
    for (int b = 0; b < 2; b++) begin
      bl = (b == 0) ? 20 : 120;
      for (int d = 0; d <= P_CYC + 3; d++) begin
        f0 = nfalls;
        send_req(mA);
        wait_falls(f0 + 1);
        chk(last_fall == mA + 2, "R4 immediate issue", last_fall, mA + 2);
        fA = last_fall;
        repeat (d) @(posedge clk);
        send_req(mB);
        wait_falls(f0 + 2);
        expB = mB + 2;
        if (fA + P_CYC > expB) expB = fA + P_CYC;
        if (last_done > fA && last_done + SET + 2 > expB) expB = last_done + SET + 2;
        chk(last_fall == expB, "R4 held request issue cycle", last_fall, expB);
        wait_dones(ndone + 0);
        while (ndone < nreq) @(posedge clk);
        repeat (P_CYC + 2) @(posedge clk);
      end
    end
    chk(nfalls == nreq, "R2 one pulse per request", nfalls, nreq);
    chk(ndone == nreq, "R9 one done per conversion", ndone, nreq);
    bl = 20;

    // R6: busy never falls
    fall_en = 0;
    f0 = nfalls;
    send_req(mA);
    wait_falls(f0 + 1);
    fA = last_fall;
    while (cyc < fA + BF - 1) @(negedge clk);
    chk(err == 1'b0, "R6 err before fall timeout", err, 0);
    @(negedge clk);
    chk(err == 1'b1, "R6 err at fall timeout", err, 1);
    fall_en = 1;
    repeat (P_CYC + 30) @(posedge clk);

    // R8: flag sticky, next conversion still completes
    dn0 = ndone;
    f0 = nfalls;
    send_req(mA);
    wait_falls(f0 + 1);
    chk(last_fall == mA + 2, "R8 issue after error", last_fall, mA + 2);
    wait_dones(dn0 + 1);
    @(negedge clk);
    chk(err == 1'b1, "R8 err still set", err, 1);
    repeat (P_CYC + 10) @(posedge clk);

    do_reset();
    @(negedge clk);
    chk(err == 1'b0, "R1 err cleared by reset", err, 0);

    // R7: busy never rises
    rise_en = 0;
    dn0 = ndone;
    f0 = nfalls;
    send_req(mA);
    wait_falls(f0 + 1);
    fA = last_fall;
    while (cyc < fA + RT - 1) @(negedge clk);
    chk(err == 1'b0, "R7 err before rise timeout", err, 0);
    @(negedge clk);
    chk(err == 1'b1, "R7 err at rise timeout", err, 1);
    // R11: late busy rise after the conversion was abandoned
    @(posedge clk); #1; busy_n = 1'b1; rise_en = 1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(ndone == dn0, "R11 no done after abandoned conversion", ndone, dn0);
    chk(conv_n == 1'b1, "R11 conv stays high", conv_n, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule